// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR-style flash controller. It observes each write cycle that reaches the device, where a cycle is a 20-bit word address plus a 16-bit data word. It recognizes the multi-cycle command sequences the device accepts. Most sequences open with a two-write unlock pair. A few single-write commands need no unlock. When the final write of a sequence arrives, the block raises a one-cycle command strobe with an operation code. The strobe also carries the address and data of that final write, so the program, erase and lockdown engines downstream can act on it.

The block also keeps the device's command modes: product-ID mode, single-pulse program mode and the erase-suspended condition. It holds a lockdown bit for every sector and a lock flag for protection block B.

Writes enter on a valid/ready stream. The decoder decides every write in the cycle it arrives, so `wr_ready` is held high and the block never applies back-pressure. A write is taken on each rising clock edge where `wr_valid` is high. The command strobe is a plain pulse with no handshake, because every command fits in a single cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: On command cycles only address bits 10..0 and data bits 7..0 are compared. The unlock pair is 0xAA at 0x555, then 0x55 at 0x2AA, so 0xAAA also matches the second write.
- R2: The unlock pair, then 0xA0 at 0x555, then any write issues op 1 (program). `cmd_addr` and `cmd_data` hold that last write, and `cmd_plane` holds its address bits 19..18.
- R3: The unlock pair, then 0x80 at 0x555, then a second unlock pair forms the erase prefix. A sixth write of 0x10 at 0x555 issues op 2 (chip erase). A sixth write of 0x30 at any address issues op 3 (sector erase).
- R4: The erase prefix followed by 0x60 at any address issues op 6 and sets `sector_locked[addr[19:15]]`. That bit stays set until reset, and at most one bit is newly set per cycle.
- R5: A lone write of 0xB0 issues op 7 and sets `erase_suspended`, but only while `erase_busy` is high. Otherwise the write is ignored.
- R6: A lone write of 0x30 issues op 8 and clears `erase_suspended`, but only while that flag is set. Otherwise the write is ignored.
- R7: The unlock pair followed by 0x90 at 0x555 issues op 9 and sets `id_mode`. Op 10 clears `id_mode`, and it is issued either by a lone 0xF0 at any address or by the unlock pair followed by 0xF0 at 0x555.
- R8: The unlock pair, then 0xC0 at 0x555, then a write issues one of two ops. A write at 0x080 issues op 12 and sets `blockb_locked` (sticky) when data bit 1 is 0. A write at any other address issues op 11.
- R9: The erase prefix followed by 0xA0 at 0x555 issues op 4 and sets `sp_mode`. While `sp_mode` is set, any lone write that is not a sequence start or an honoured single command issues op 5. Priority, highest first: sequence start, suspend, resume, ID exit.
- R10: A write that does not match the expected next cycle abandons the sequence without a strobe. If that write is 0xAA at 0x555, it starts a new sequence.
- R11: A synchronous reset clears the sequence state, all mode flags, all sector lockdown bits, `blockb_locked` and `cmd_valid`.
- R12: `wr_ready` is always high. `cmd_valid` is high only in the cycle after the edge that accepted the final write of a command, and it is low after every other write and every idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A write cycle is presented |
| wr_ready | output | 1 | Always high; writes are never stalled |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| erase_busy | input | 1 | An erase is running (enables suspend) |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Operation code of the strobed command |
| cmd_addr | output | 20 | Address of the final write of the command |
| cmd_data | output | 16 | Data of the final write of the command |
| cmd_plane | output | 2 | Plane select, address bits 19..18 of `cmd_addr` |
| id_mode | output | 1 | Product-ID mode active |
| sp_mode | output | 1 | Single-pulse program mode active |
| erase_suspended | output | 1 | Erase is suspended |
| sector_locked | output | 32 | Per-sector lockdown bits |
| blockb_locked | output | 1 | Protection block B locked |

## Verification
A sequencer left in the wrong state shows up at the ports one edge after the write that should finish a command. The strobe is then either missing or carries the wrong code, or a strobe appears on a write that should only advance or abandon a sequence. A corrupted mode register is visible at once on its flag pin. It also shows later as a wrongly honoured or ignored single write: a resume with no suspend in effect, or a stray program strobe in single-pulse mode. A lockdown bit that is lost or set on the wrong sector is seen on `sector_locked` in the cycle after the lockdown write. Reset must clear it, and nothing else may.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_PROG       = 4'd1,
    OP_CHIP_ERASE = 4'd2,
    OP_SECT_ERASE = 4'd3,
    OP_SP_ENTER   = 4'd4,
    OP_SP_PROG    = 4'd5,
    OP_LOCKDOWN   = 4'd6,
    OP_SUSPEND    = 4'd7,
    OP_RESUME     = 4'd8,
    OP_ID_ENTER   = 4'd9,
    OP_ID_EXIT    = 4'd10,
    OP_PREG_PROG  = 4'd11,
    OP_PREG_LOCK  = 4'd12
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_ERA80,
    S_UNL4,
    S_UNL5,
    S_PROGW,
    S_PREGW
  } seq_e;

  typedef struct packed {
    logic       at_first;   // low address bits equal 0x555
    logic       at_second;  // low address bits equal 0x2AA
    logic       at_preg;    // low address bits equal 0x080
    logic [7:0] code;       // low data byte
  } wr_dec_t;

  localparam logic [7:0] C_UNLOCK_A = 8'hAA;
  localparam logic [7:0] C_UNLOCK_B = 8'h55;
  localparam logic [7:0] C_PROG     = 8'hA0;
  localparam logic [7:0] C_ERASE    = 8'h80;
  localparam logic [7:0] C_CHIP     = 8'h10;
  localparam logic [7:0] C_SECT     = 8'h30;
  localparam logic [7:0] C_LOCK     = 8'h60;
  localparam logic [7:0] C_SUSPEND  = 8'hB0;
  localparam logic [7:0] C_RESUME   = 8'h30;
  localparam logic [7:0] C_ID_IN    = 8'h90;
  localparam logic [7:0] C_ID_OUT   = 8'hF0;
  localparam logic [7:0] C_PREG     = 8'hC0;

endpackage

// File: rtl/fcsd_match.sv
module fcsd_match
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 11
) (
  input  logic [CMP_W-1:0] low_addr,
  input  logic [7:0]       low_data,
  output wr_dec_t          dec
);

  localparam logic [CMP_W-1:0] K_FIRST  = CMP_W'(16'h0555);
  localparam logic [CMP_W-1:0] K_SECOND = CMP_W'(16'h02AA);
  localparam logic [CMP_W-1:0] K_PREG   = CMP_W'(16'h0080);

  always_comb begin
    dec.at_first  = (low_addr == K_FIRST);
    dec.at_second = (low_addr == K_SECOND);
    dec.at_preg   = (low_addr == K_PREG);
    dec.code      = low_data;
  end

endmodule

// File: rtl/fcsd_seq.sv
module fcsd_seq
  import flash_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_fire,
  input  wr_dec_t dec,
  input  logic    erase_busy,
  input  logic    suspended,
  input  logic    sp_mode,
  output op_e     op
);

  seq_e state_q, state_d;
  logic is_start, is_second;

  always_comb begin
    is_start  = dec.at_first && (dec.code == C_UNLOCK_A);
    is_second = dec.at_second && (dec.code == C_UNLOCK_B);
    op        = OP_NONE;
    state_d   = state_q;
    if (wr_fire) begin
      unique case (state_q)
        S_IDLE: begin
          if (is_start)                                      state_d = S_UNL1;
          else if (dec.code == C_SUSPEND && erase_busy)      op = OP_SUSPEND;
          else if (dec.code == C_RESUME && suspended)        op = OP_RESUME;
          else if (dec.code == C_ID_OUT)                     op = OP_ID_EXIT;
          else if (sp_mode)                                  op = OP_SP_PROG;
        end
        S_UNL1: begin
          if (is_second)     state_d = S_UNL2;
          else if (is_start) state_d = S_UNL1;
          else               state_d = S_IDLE;
        end
        S_UNL2: begin
          state_d = S_IDLE;
          if (dec.at_first) begin
            unique case (dec.code)
              C_PROG:     state_d = S_PROGW;
              C_ERASE:    state_d = S_ERA80;
              C_PREG:     state_d = S_PREGW;
              C_UNLOCK_A: state_d = S_UNL1;
              C_ID_IN:    op = OP_ID_ENTER;
              C_ID_OUT:   op = OP_ID_EXIT;
              default:    state_d = S_IDLE;
            endcase
          end
        end
        S_ERA80: state_d = is_start ? S_UNL4 : S_IDLE;
        S_UNL4: begin
          if (is_second)     state_d = S_UNL5;
          else if (is_start) state_d = S_UNL1;
          else               state_d = S_IDLE;
        end
        S_UNL5: begin
          state_d = S_IDLE;
          if (dec.code == C_SECT)                        op = OP_SECT_ERASE;
          else if (dec.code == C_LOCK)                   op = OP_LOCKDOWN;
          else if (dec.at_first && dec.code == C_CHIP)   op = OP_CHIP_ERASE;
          else if (dec.at_first && dec.code == C_PROG)   op = OP_SP_ENTER;
          else if (is_start)                             state_d = S_UNL1;
        end
        S_PROGW: begin
          op      = OP_PROG;
          state_d = S_IDLE;
        end
        S_PREGW: begin
          op      = dec.at_preg ? OP_PREG_LOCK : OP_PREG_PROG;
          state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/fcsd_modes.sv
module fcsd_modes
  import flash_cmd_pkg::*;
#(
  parameter int SECT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  op_e                   op,
  input  logic [SECT_W-1:0]     sect_idx,
  input  logic                  prot_bit,
  output logic                  id_mode,
  output logic                  sp_mode,
  output logic                  suspended,
  output logic [(1<<SECT_W)-1:0] sector_locked,
  output logic                  blockb_locked
);

  localparam int NUM_SECT = 1 << SECT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_mode       <= 1'b0;
      sp_mode       <= 1'b0;
      suspended     <= 1'b0;
      blockb_locked <= 1'b0;
    end else begin
      if (op == OP_ID_ENTER)                   id_mode       <= 1'b1;
      else if (op == OP_ID_EXIT)               id_mode       <= 1'b0;
      if (op == OP_SP_ENTER)                   sp_mode       <= 1'b1;
      if (op == OP_SUSPEND)                    suspended     <= 1'b1;
      else if (op == OP_RESUME)                suspended     <= 1'b0;
      if (op == OP_PREG_LOCK && !prot_bit)     blockb_locked <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    always_ff @(posedge clk) begin
      if (rst)
        sector_locked[i] <= 1'b0;
      else if (op == OP_LOCKDOWN && sect_idx == SECT_W'(i))
        sector_locked[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int CMP_W    = 11,
  parameter int SECT_LSB = 15,
  parameter int PROT_BIT = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_valid,
  output logic                              wr_ready,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              erase_busy,
  output logic                              cmd_valid,
  output logic [3:0]                        cmd_op,
  output logic [ADDR_W-1:0]                 cmd_addr,
  output logic [DATA_W-1:0]                 cmd_data,
  output logic [1:0]                        cmd_plane,
  output logic                              id_mode,
  output logic                              sp_mode,
  output logic                              erase_suspended,
  output logic [(1<<(ADDR_W-SECT_LSB))-1:0] sector_locked,
  output logic                              blockb_locked
);

  localparam int SECT_W  = ADDR_W - SECT_LSB;
  localparam int PLANE_W = 2;

  logic    wr_fire;
  wr_dec_t dec;
  op_e     op;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  fcsd_match #(.CMP_W(CMP_W)) u_match (
    .low_addr (wr_addr[CMP_W-1:0]),
    .low_data (wr_data[7:0]),
    .dec      (dec)
  );

  fcsd_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_fire    (wr_fire),
    .dec        (dec),
    .erase_busy (erase_busy),
    .suspended  (erase_suspended),
    .sp_mode    (sp_mode),
    .op         (op)
  );

  fcsd_modes #(.SECT_W(SECT_W)) u_modes (
    .clk           (clk),
    .rst           (rst),
    .op            (op),
    .sect_idx      (wr_addr[ADDR_W-1:SECT_LSB]),
    .prot_bit      (wr_data[PROT_BIT]),
    .id_mode       (id_mode),
    .sp_mode       (sp_mode),
    .suspended     (erase_suspended),
    .sector_locked (sector_locked),
    .blockb_locked (blockb_locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= 4'd0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= (op != OP_NONE);
      if (op != OP_NONE) begin
        cmd_op   <= op;
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
    end
  end

  assign cmd_plane = cmd_addr[ADDR_W-1 -: PLANE_W];

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int NUM_SECT = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_valid,
  input logic                erase_busy,
  input logic                cmd_valid,
  input logic [3:0]          cmd_op,
  input logic                id_mode,
  input logic                erase_suspended,
  input logic [NUM_SECT-1:0] sector_locked,
  input logic                blockb_locked
);

  a_r12_strobe_follows_write: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(wr_valid));

  a_r5_suspend_source: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(erase_suspended)) |-> (cmd_valid && cmd_op == 4'd7 && $past(erase_busy)));

  a_r6_resume_source: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(erase_suspended)) |-> (cmd_valid && cmd_op == 4'd8));

  a_r7_id_entry_source: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(id_mode)) |-> (cmd_valid && cmd_op == 4'd9));

  a_r4_locks_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((sector_locked & $past(sector_locked)) == $past(sector_locked)));

  a_r4_one_lock_per_cycle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(sector_locked ^ $past(sector_locked)) <= 1));

  a_r8_blockb_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(blockb_locked)) |-> blockb_locked);

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!cmd_valid && !id_mode && !erase_suspended && sector_locked == '0 && !blockb_locked));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .NUM_SECT(1 << (ADDR_W - SECT_LSB))
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .wr_valid        (wr_valid),
  .erase_busy      (erase_busy),
  .cmd_valid       (cmd_valid),
  .cmd_op          (cmd_op),
  .id_mode         (id_mode),
  .erase_suspended (erase_suspended),
  .sector_locked   (sector_locked),
  .blockb_locked   (blockb_locked)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        erase_busy = 1'b0;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [19:0] cmd_addr;
  logic [15:0] cmd_data;
  logic [1:0]  cmd_plane;
  logic        id_mode, sp_mode, erase_suspended, blockb_locked;
  logic [31:0] sector_locked;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .erase_busy(erase_busy),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_plane(cmd_plane), .id_mode(id_mode),
    .sp_mode(sp_mode), .erase_suspended(erase_suspended),
    .sector_locked(sector_locked), .blockb_locked(blockb_locked)
  );

  // row: valid, addr, data, busy, expected strobe, expected op
  function automatic logic [42:0] mk(logic v, logic [19:0] a, logic [15:0] d,
                                     logic b, logic ev, logic [3:0] eop);
    return {v, a, d, b, ev, eop};
  endfunction

  localparam int NV = 60;
  localparam logic [42:0] VEC [NV] = '{
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R2 word program
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h00A0, 0, 0, 0),
    mk(1, 20'hC0123, 16'h1234, 0, 1, 1),
    mk(1, 20'hFF555, 16'h12AA, 0, 0, 0),  // R1 upper bits ignored, R3 chip erase
    mk(1, 20'h002AA, 16'hFF55, 0, 0, 0),
    mk(1, 20'h00555, 16'h0080, 0, 0, 0),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),
    mk(1, 20'h002AA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h0010, 0, 1, 2),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R3 sector erase
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h0080, 0, 0, 0),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h48000, 16'h0030, 0, 1, 3),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R4 lockdown sector 17
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h0080, 0, 0, 0),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h88000, 16'h0060, 0, 1, 6),
    mk(1, 20'h00000, 16'h00B0, 0, 0, 0),  // R5 ignored while not busy
    mk(1, 20'h00000, 16'h00B0, 1, 1, 7),  // R5 suspend
    mk(1, 20'h00123, 16'h0030, 0, 1, 8),  // R6 resume
    mk(1, 20'h00123, 16'h0030, 0, 0, 0),  // R6 ignored when not suspended
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R7 ID entry
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h0090, 0, 1, 9),
    mk(1, 20'h00777, 16'h00F0, 0, 1, 10), // R7 lone exit
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R7 unlocked exit
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h00F0, 0, 1, 10),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R10 mismatch abandons
    mk(1, 20'h00AAA, 16'h0056, 0, 0, 0),
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h00A0, 0, 0, 0),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R10 restart on AA@555
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h00A0, 0, 0, 0),
    mk(1, 20'h30000, 16'h5A5A, 0, 1, 1),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R8 block B lock
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h00C0, 0, 0, 0),
    mk(1, 20'h00080, 16'h0000, 0, 1, 12),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R8 protection program
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h00C0, 0, 0, 0),
    mk(1, 20'h00100, 16'h5555, 0, 1, 11),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),  // R9 single-pulse entry
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h0080, 0, 0, 0),
    mk(1, 20'h00555, 16'h00AA, 0, 0, 0),
    mk(1, 20'h00AAA, 16'h0055, 0, 0, 0),
    mk(1, 20'h00555, 16'h00A0, 0, 1, 4),
    mk(1, 20'h12345, 16'hBEEF, 0, 1, 5),  // R9 lone program
    mk(1, 20'h00000, 16'h00F0, 0, 1, 10), // R9 exit outranks program
    mk(0, 20'h00555, 16'h00AA, 0, 0, 0),  // R12 no write, no strobe
    mk(1, 20'h00456, 16'h0001, 0, 1, 5)
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [19:0] a, logic [15:0] d, logic b);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; erase_busy = b;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic wr(logic [19:0] a, logic [15:0] d, logic b);
    drive(1'b1, a, d, b);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    check("R11 cmd_valid", 32'(cmd_valid), 0);
    check("R11 sector_locked", sector_locked, 0);
    check("R11 modes", {id_mode, sp_mode, erase_suspended, blockb_locked}, 0);
    check("R12 wr_ready", 32'(wr_ready), 1);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] r;
      r = VEC[i];
      drive(r[42], r[41:22], r[21:6], r[5]);
      check($sformatf("vector %0d cmd_valid", i), 32'(cmd_valid), 32'(r[4]));
      if (r[4]) check($sformatf("vector %0d cmd_op", i), 32'(cmd_op), 32'(r[3:0]));
    end

    check("R4 lockdown bit 17", sector_locked, 32'h0002_0000);
    check("R8 block B locked", 32'(blockb_locked), 1);
    check("R9 sp_mode set", 32'(sp_mode), 1);
    check("R7 id_mode cleared", 32'(id_mode), 0);
    check("R6 suspended cleared", 32'(erase_suspended), 0);

    // R2 target address, data and plane
    wr(20'h00555, 16'h00AA, 0);
    wr(20'h00AAA, 16'h0055, 0);
    wr(20'h00555, 16'h00A0, 0);
    wr(20'hC1234, 16'hABCD, 0);
    check("R2 strobe", 32'(cmd_valid), 1);
    check("R2 cmd_addr", 32'(cmd_addr), 32'h000C_1234);
    check("R2 cmd_data", 32'(cmd_data), 32'h0000_ABCD);
    check("R2 cmd_plane", 32'(cmd_plane), 3);
    drive(1'b0, 20'h0, 16'h0, 0);
    check("R12 strobe one cycle", 32'(cmd_valid), 0);

    // R7 id mode entered
    wr(20'h00555, 16'h00AA, 0);
    wr(20'h00AAA, 16'h0055, 0);
    wr(20'h00555, 16'h0090, 0);
    check("R7 id_mode set", 32'(id_mode), 1);

    // R5 suspend flag
    wr(20'h00000, 16'h00B0, 1);
    check("R5 suspended set", 32'(erase_suspended), 1);

    // R4 second lockdown, first stays
    wr(20'h00555, 16'h00AA, 0);
    wr(20'h00AAA, 16'h0055, 0);
    wr(20'h00555, 16'h0080, 0);
    wr(20'h00555, 16'h00AA, 0);
    wr(20'h00AAA, 16'h0055, 0);
    wr(20'h18000, 16'h0060, 0);
    check("R4 lockdown bits 17 and 3", sector_locked, 32'h0002_0008);

    // R11 reset clears everything
    do_reset();
    check("R11 sector_locked after reset", sector_locked, 0);
    check("R11 modes after reset", {id_mode, sp_mode, erase_suspended, blockb_locked}, 0);
    check("R11 cmd_valid after reset", 32'(cmd_valid), 0);
    wr(20'h00123, 16'hBEEF, 0);
    check("R9 lone write ignored outside sp_mode", 32'(cmd_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule